// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital control for a multi-channel analog-to-digital converter. Software-side logic writes a control word with three fields: a 2-bit conversion mode, a 4-bit channel number and a start bit. From that word the sequencer drives the channel multiplexer select and a one-cycle start strobe to the converter. The converter is modelled inside the block as a fixed-latency timer that returns a done pulse a set number of cycles after each strobe. Each completed conversion loads a result register with the sampled data and the channel it came from, and a busy flag reports whether any activity is in progress.

There are four modes: one conversion of a single channel, repeated conversion of a single channel, one descending scan and repeated descending scans. Control writes never disturb work already under way. They land in a staged register that the sequencer reads only at defined boundaries: the end of a fixed-channel conversion, or the end of a scan after channel 0 has been converted. While the converter is idle, only the start bit launches work. Changing the mode without setting start does nothing.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Mode code 00 (fixed, once) converts the written channel a single time, then drops busy and clears the start bit.
- R2: Mode code 01 (fixed, repeating) converts the same channel over and over. Once the start bit is written to 0, the converter stops after the conversion in progress.
- R3: Mode code 10 (scan, once) converts the selected channel and then each lower channel down to channel 0, one conversion each, and then ends. Mode code 11 (scan, repeating) starts the scan again from the staged channel while start stays 1.
- R4: A write made during a scan leaves that scan unchanged. Its channel and start bit are used only after channel 0 has been converted.
- R5: A write made during a fixed-channel conversion takes effect when that conversion completes, with mode, channel and start all read at that moment. A staged repeating mode with start 1 then launches the staged channel.
- R6: If the staged mode is a scan mode when a fixed-channel conversion of channel n>0 completes, channels n-1 down to 0 are converted next, whatever the start bit and staged channel hold.
- R7: While idle, a write with start 0 launches no conversion in any mode, including right after a completed fixed-channel conversion of a channel above 0.
- R8: busy is 1 from the launch of a conversion or sequence until it ends, and 0 while idle.
- R9: On each completed conversion, res_valid pulses for one cycle. res_chan then holds the converted channel and res_data holds the conv_data value present when the conversion completed. res_chan keeps the last converted channel until the next result.
- R10: conv_go is a one-cycle pulse and conv_sel is stable while a conversion runs. res_valid rises exactly LAT+1 cycles after conv_go.
- R11: After reset, busy, conv_go, start_q and res_valid are 0 and res_chan is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the staged control word |
| cfg_mode | input | 2 | Mode: 00 fixed once, 01 fixed repeat, 10 scan once, 11 scan repeat |
| cfg_chan | input | 4 | Channel number (scan start channel in scan modes) |
| cfg_start | input | 1 | Start bit |
| conv_data | input | 10 | Converter sample, taken when a conversion completes |
| conv_sel | output | 4 | Channel multiplexer select |
| conv_go | output | 1 | One-cycle conversion start strobe |
| busy | output | 1 | Conversion or sequence in progress |
| start_q | output | 1 | Current staged start bit |
| res_valid | output | 1 | One-cycle pulse when a new result is loaded |
| res_chan | output | 4 | Channel of the latest result |
| res_data | output | 10 | Data of the latest result |

## Verification
The channel stream is checked in each mode from an idle launch, using random channels and modes and the directed edge channels 0 and 15. This separates the single-conversion behaviour from the descending scan and shows where each one ends. Writes are then timed to land inside a running conversion or scan: a start clear, a channel change, and a switch from fixed to scan with start 0. These cases tell apart deferral to the end of a conversion, deferral to the end of a scan, and the continuation from channel n-1. The idle writes with start 0 tell a correct sequencer apart from one that launches a scan on a mode change alone. Each result is also checked for its data tag and its exact latency from the start strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FIX_ONCE  = 2'b00,
    MODE_FIX_LOOP  = 2'b01,
    MODE_SCAN_ONCE = 2'b10,
    MODE_SCAN_LOOP = 2'b11
  } scan_mode_e;

  function automatic logic is_scan(scan_mode_e m);
    return m[1];
  endfunction

  function automatic logic is_loop(scan_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/adc_cfg_stage.sv
module adc_cfg_stage
  import adc_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  scan_mode_e    wr_mode,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_start,
  input  logic          clr_start,
  output scan_mode_e    p_mode,
  output logic [CW-1:0] p_chan,
  output logic          p_start
);

  // A write in the same cycle as a completion clear wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      p_mode  <= MODE_FIX_ONCE;
      p_chan  <= '0;
      p_start <= 1'b0;
    end else if (we) begin
      p_mode  <= wr_mode;
      p_chan  <= wr_chan;
      p_start <= wr_start;
    end else if (clr_start) begin
      p_start <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int LAT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic done
);

  localparam int CNTW = (LAT > 1) ? $clog2(LAT + 1) : 1;
  localparam logic [CNTW-1:0] LOAD = CNTW'(LAT - 1);

  logic            active;
  logic [CNTW-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - CNTW'(1);
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  scan_mode_e    p_mode,
  input  logic [CW-1:0] p_chan,
  input  logic          p_start,
  input  logic          done,
  output logic          go,
  output logic [CW-1:0] sel,
  output logic          busy,
  output logic          clr_start
);

  scan_mode_e    mode_q, mode_n;
  logic [CW-1:0] sel_n;
  logic          busy_n, go_n;
  logic          at_zero;

  assign at_zero = (sel == '0);

  always_comb begin
    mode_n    = mode_q;
    sel_n     = sel;
    busy_n    = busy;
    go_n      = 1'b0;
    clr_start = 1'b0;
    if (!busy) begin
      if (p_start) begin
        busy_n = 1'b1;
        go_n   = 1'b1;
        sel_n  = p_chan;
        mode_n = p_mode;
      end
    end else if (done) begin
      if (!at_zero && (is_scan(mode_q) || is_scan(p_mode))) begin
        // step down; a fixed conversion turns into a scan tail
        go_n  = 1'b1;
        sel_n = sel - CW'(1);
        if (!is_scan(mode_q)) mode_n = p_mode;
      end else if (p_start && is_loop(p_mode)) begin
        go_n   = 1'b1;
        sel_n  = p_chan;
        mode_n = p_mode;
      end else begin
        busy_n    = 1'b0;
        clr_start = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_FIX_ONCE;
      sel    <= '0;
      busy   <= 1'b0;
      go     <= 1'b0;
    end else begin
      mode_q <= mode_n;
      sel    <= sel_n;
      busy   <= busy_n;
      go     <= go_n;
    end
  end

  // R3
  scan_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && done && is_scan(mode_q) && !at_zero) |=> (go && sel == $past(sel) - CW'(1)));

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(sel));

  // R10
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int CW = 4,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [CW-1:0] chan,
  input  logic [DW-1:0] data,
  output logic          valid,
  output logic [CW-1:0] res_chan,
  output logic [DW-1:0] res_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      res_chan <= '0;
      res_data <= '0;
    end else begin
      valid <= done;
      if (done) begin
        res_chan <= chan;
        res_data <= data;
      end
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CW  = 4,
  parameter int DW  = 10,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_mode,
  input  logic [CW-1:0] cfg_chan,
  input  logic          cfg_start,
  input  logic [DW-1:0] conv_data,
  output logic [CW-1:0] conv_sel,
  output logic          conv_go,
  output logic          busy,
  output logic          start_q,
  output logic          res_valid,
  output logic [CW-1:0] res_chan,
  output logic [DW-1:0] res_data
);

  scan_mode_e    p_mode;
  logic [CW-1:0] p_chan;
  logic          clr_start;
  logic          conv_done;

  adc_cfg_stage #(.CW(CW)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wr_mode   (scan_mode_e'(cfg_mode)),
    .wr_chan   (cfg_chan),
    .wr_start  (cfg_start),
    .clr_start (clr_start),
    .p_mode    (p_mode),
    .p_chan    (p_chan),
    .p_start   (start_q)
  );

  adc_seq_fsm #(.CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .p_mode    (p_mode),
    .p_chan    (p_chan),
    .p_start   (start_q),
    .done      (conv_done),
    .go        (conv_go),
    .sel       (conv_sel),
    .busy      (busy),
    .clr_start (clr_start)
  );

  adc_conv_timer #(.LAT(LAT)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .go   (conv_go),
    .done (conv_done)
  );

  adc_result_reg #(.CW(CW), .DW(DW)) u_res (
    .clk      (clk),
    .rst      (rst),
    .done     (conv_done),
    .chan     (conv_sel),
    .data     (conv_data),
    .valid    (res_valid),
    .res_chan (res_chan),
    .res_data (res_data)
  );

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_q) |=> !conv_go);

  // R8
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done |-> busy);

  // R9
  result_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(conv_done));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam int DW    = 10;
  localparam int LAT   = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic [CW-1:0] cfg_chan = '0;
  logic          cfg_start = 1'b0;
  logic [DW-1:0] conv_data;
  logic [CW-1:0] conv_sel;
  logic          conv_go, busy, start_q, res_valid;
  logic [CW-1:0] res_chan;
  logic [DW-1:0] res_data;

  adc_seq_ctrl #(.CW(CW), .DW(DW), .LAT(LAT)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_chan(cfg_chan), .cfg_start(cfg_start), .conv_data(conv_data),
    .conv_sel(conv_sel), .conv_go(conv_go), .busy(busy), .start_q(start_q),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] sample_of(input logic [CW-1:0] ch);
    return DW'(int'(ch) * 37 + 5);
  endfunction

  assign conv_data = sample_of(conv_sel);

  int n_chk = 0;
  int n_bad = 0;
  int rec[$];
  int expq[$];
  int cyc = 0;
  int go_cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_list(input string req, input string what);
    bit ok;
    ok = (rec.size() == expq.size());
    if (ok) foreach (expq[i]) if (rec[i] != expq[i]) ok = 0;
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %p expected %p", req, what, rec, expq);
    end
  endtask

  function automatic void fill_scan(input int from);
    for (int c = from; c >= 0; c--) expq.push_back(c);
  endfunction

  // result monitor: data tag (R9) and latency (R10)
  always @(negedge clk) begin
    cyc++;
    if (!rst && res_valid) begin
      rec.push_back(int'(res_chan));
      check(res_data == sample_of(res_chan), "R9", "result data tag",
            int'(res_data), int'(sample_of(res_chan)));
      check(cyc - go_cyc == LAT + 1, "R10", "strobe to result latency",
            cyc - go_cyc, LAT + 1);
    end
    if (!rst && conv_go) go_cyc = cyc;
  end

  task automatic wr(input int m, input int c, input bit s);
    cfg_mode  = 2'(m);
    cfg_chan  = CW'(c);
    cfg_start = s;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    repeat (3) @(negedge clk);
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    #1;
    check(!busy, req, "busy low after activity", int'(busy), 0);
  endtask

  task automatic wait_res(input int n, input string req);
    int t = 0;
    while (rec.size() < n && t < 3000) begin
      @(negedge clk);
      #1;
      t++;
    end
    check(rec.size() >= n, req, "result count reached", rec.size(), n);
  endtask

  task automatic fresh();
    rec.delete();
    expq.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R11 reset state
    check(busy == 0,      "R11", "busy after reset", int'(busy), 0);
    check(conv_go == 0,   "R11", "conv_go after reset", int'(conv_go), 0);
    check(start_q == 0,   "R11", "start after reset", int'(start_q), 0);
    check(res_valid == 0, "R11", "res_valid after reset", int'(res_valid), 0);
    check(res_chan == 0,  "R11", "res_chan after reset", int'(res_chan), 0);

    // R7: idle scan mode write without start
    fresh();
    wr(2, 5, 0);
    repeat (30) @(negedge clk);
    #1;
    check(rec.size() == 0, "R7", "no result from idle mode write", rec.size(), 0);
    check(!busy, "R7", "stay idle after mode write", int'(busy), 0);

    // R1 + R8: fixed once on channel 9
    fresh();
    wr(0, 9, 1);
    @(negedge clk);
    #1;
    check(busy == 1, "R8", "busy after launch", int'(busy), 1);
    wait_idle("R8");
    expq.push_back(9);
    cmp_list("R1", "fixed once stream");
    check(start_q == 0, "R1", "start cleared after single", int'(start_q), 0);
    check(res_chan == 9, "R9", "last channel held", int'(res_chan), 9);

    // R3: scan once from 3 and from 0
    fresh();
    wr(2, 3, 1);
    wait_idle("R3");
    fill_scan(3);
    cmp_list("R3", "scan once from 3");
    check(start_q == 0, "R3", "start cleared after scan", int'(start_q), 0);
    fresh();
    wr(2, 0, 1);
    wait_idle("R3");
    fill_scan(0);
    cmp_list("R3", "scan once from 0");

    // R7: after a fixed conversion of channel 7, mode change alone stays idle
    fresh();
    wr(0, 7, 1);
    wait_idle("R7");
    fresh();
    wr(2, 7, 0);
    repeat (30) @(negedge clk);
    #1;
    check(rec.size() == 0, "R7", "no scan after fixed conversion", rec.size(), 0);
    check(!busy, "R7", "idle after fixed conversion", int'(busy), 0);
    wr(2, 3, 1);
    wait_idle("R7");
    fill_scan(3);
    cmp_list("R7", "start bit launches scan");

    // R2: fixed repeat, stop after current
    fresh();
    wr(1, 6, 1);
    wait_res(3, "R2");
    wr(1, 6, 0);
    wait_idle("R2");
    repeat (4) expq.push_back(6);
    cmp_list("R2", "fixed repeat stops after current");

    // R3: scan repeat
    fresh();
    wr(3, 1, 1);
    wait_res(5, "R3");
    wr(3, 1, 0);
    wait_idle("R3");
    fill_scan(1); fill_scan(1); fill_scan(1);
    cmp_list("R3", "scan repeat stream");

    // R4: writes during scan deferred to end of scan
    fresh();
    wr(3, 2, 1);
    wait_res(1, "R4");
    wr(3, 4, 1);
    wait_res(4, "R4");
    wr(3, 4, 0);
    wait_idle("R4");
    fill_scan(2); fill_scan(4);
    cmp_list("R4", "scan write deferred");

    // R6: fixed to scan switch mid conversion, start 0
    fresh();
    wr(0, 5, 1);
    @(negedge clk);
    wr(2, 12, 0);
    wait_idle("R6");
    fill_scan(5);
    cmp_list("R6", "scan tail after fixed conversion");
    check(start_q == 0, "R6", "start after scan tail", int'(start_q), 0);

    // R5: fixed write during conversion applied at completion
    fresh();
    wr(1, 1, 1);
    @(negedge clk);
    wr(1, 8, 1);
    wait_res(2, "R5");
    wr(1, 8, 0);
    wait_idle("R5");
    expq = '{1, 8, 8};
    cmp_list("R5", "channel change at completion");

    // R1: fixed once, channel change during conversion does not relaunch
    fresh();
    wr(0, 2, 1);
    @(negedge clk);
    wr(0, 11, 0);
    wait_idle("R1");
    expq.push_back(2);
    cmp_list("R1", "single ends despite staged write");

    // random single-mode launches, with edge channel 15 first
    for (int i = 0; i < 20; i++) begin
      int m, c;
      m = (i == 0 || ($urandom % 2) == 1) ? 2 : 0;
      c = (i == 0) ? 15 : int'($urandom % 16);
      fresh();
      wr(m, c, 1);
      wait_idle(m == 2 ? "R3" : "R1");
      if (m == 2) fill_scan(c);
      else expq.push_back(c);
      cmp_list(m == 2 ? "R3" : "R1", "random single launch");
    end

    summary();
    $finish;
  end

endmodule